// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block is the control path that an 8-bit processor core follows when it enters reset, a non-maskable interrupt, a maskable interrupt or a software break. When it takes an entry, it writes the return address and the status byte onto a stack in page 1. It then reads a two-byte vector through a simple synchronous memory port and presents the new program counter, the stack pointer and the status byte to the rest of the core. The block does no instruction decode or execution. The core gives it the current program counter, an instruction-boundary strobe, a break request, a clear-mask request, and a flag-restore write that stands for a pull or return from the stack.

The memory port has one-cycle read latency. The address presented in one cycle returns its data on `mem_rdata` in the next cycle. Status bit positions are: C=0, Z=1, I=2, D=3, B=4, R=5 (reserved), V=6, N=7. The stack byte for stack pointer `s` sits at address 0x0100+s. The vectors are little-endian pairs at 0xFFFA (non-maskable), 0xFFFC (reset) and 0xFFFE (maskable and break).

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held and until the reset entry completes, `sp_out` is 0xFF, `status_out` is 0x22 and `gpr_clear` is 1. When the reset entry completes, `pc_out` is loaded from 0xFFFC (low) and 0xFFFD (high), `entry_cost` is 0 and `gpr_clear` returns to 0.
- R2: Every interrupt or break entry writes three bytes, in this order: PC high byte at 0x0100+SP, PC low byte at 0x0100+SP-1, and the status byte at 0x0100+SP-2. The stack pointer decreases by one after each write, so it ends 3 lower.
- R3: The new PC is read little-endian from 0xFFFA/0xFFFB for a non-maskable entry and from 0xFFFE/0xFFFF for a maskable or break entry. `done` is high for exactly one cycle, when `pc_out` becomes valid.
- R4: A one-cycle pulse on `nmi_req` is latched. It is serviced at the next `boundary`, and it is held if it arrives during an entry. When both requests are pending at a boundary, the non-maskable one is taken first.
- R5: A maskable request (`irq_req` level high) is taken at a boundary only when status bit I is 0. If I is 1, nothing happens: no stack write, and SP and PC are unchanged.
- R6: The pushed status has bit B=0 for hardware interrupts and B=1 for a break, always with R=1. A break pushes `pc_in`+1 as its return address.
- R7: Every entry clears status bit D. Maskable and break entries set bit I. A non-maskable entry leaves bit I unchanged.
- R8: `done` rises on the 7th rising clock edge, counting the edge that accepts the request as the 1st. `entry_cost` then reads 7.
- R9: A `cli_req` pulse clears bit I. If I was 1 and `irq_req` is high, the maskable entry starts on that same edge without waiting for a boundary, and the pushed status has I=0.
- R10: A `restore_we` write loads `restore_val` into the status with bit R forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | Instruction-boundary strobe |
| brk_req | input | 1 | Software break, valid with `boundary` |
| cli_req | input | 1 | Clear interrupt mask (not with `boundary`) |
| nmi_req | input | 1 | Non-maskable request pulse |
| irq_req | input | 1 | Maskable request level |
| restore_we | input | 1 | Status restore strobe |
| restore_val | input | 8 | Status value popped from the stack |
| pc_in | input | 16 | Address of the next instruction |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Read data, one cycle after the address |
| pc_out | output | 16 | New program counter |
| sp_out | output | 8 | Stack pointer |
| status_out | output | 8 | Status byte |
| done | output | 1 | One-cycle pulse when `pc_out` is valid |
| busy | output | 1 | Entry sequence in progress |
| gpr_clear | output | 1 | Clear A, X and Y (reset entry) |
| entry_cost | output | 3 | Clock cost of the last entry |

## Verification
The bench starts each kind of entry from a different status: I clear, I set, D set, and I cleared by a clear-mask request. Comparing the pushed status bytes and the final status shows whether the B, I and D rules are applied per entry kind, rather than being copied or set for all kinds. Both requests are raised together with I clear to show which one wins. A non-maskable pulse is raised in the middle of a maskable entry to check that it is held until the next boundary and is neither lost nor taken early. Because the program counter and stack pointer move on every entry, each stack byte is found at a unique address, which exposes any push-order or decrement error.

// File: rtl/ies_pkg.sv
// Shared constants and types for the interrupt/reset entry sequencer.
// Assumes an 8-bit data path, a 16-bit address space and a page-1 stack.
package ies_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Status bit positions
    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_I = 2;
    localparam int FB_D = 3;
    localparam int FB_B = 4;
    localparam int FB_R = 5;
    localparam int FB_V = 6;
    localparam int FB_N = 7;

    localparam logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_RST = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE;
    localparam logic [7:0]        STACK_PAGE = 8'h01;

    localparam int ENTRY_CLOCKS = 7;
    localparam int COST_W = $clog2(ENTRY_CLOCKS + 1);

    typedef enum logic [1:0] {K_RST, K_NMI, K_IRQ, K_BRK} entry_kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_PSH_H, S_PSH_L, S_PSH_P, S_VLO, S_VHI, S_VWAIT
    } seq_state_t;
endpackage

// File: rtl/ies_arbiter.sv
// Chooses which entry, if any, starts in this cycle.
// Assumes it is consulted only while the sequencer is idle. Priority order:
// non-maskable, unmasked maskable at a boundary, clear-mask, break.
module ies_arbiter
    import ies_pkg::*;
(
    input  logic        boundary,
    input  logic        brk,
    input  logic        cli,
    input  logic        nmi_pend,
    input  logic        irq_lvl,
    input  logic        i_flag,
    output logic        start,
    output entry_kind_t kind,
    output logic        clr_i
);
    // Priority selection of the next entry
    always_comb begin
        start = 1'b0;
        kind  = K_IRQ;
        clr_i = 1'b0;
        if (boundary && nmi_pend) begin
            start = 1'b1;
            kind  = K_NMI;
        end else if (boundary && irq_lvl && !i_flag) begin
            start = 1'b1;
            kind  = K_IRQ;
        end else if (cli) begin
            clr_i = 1'b1;
            if (i_flag && irq_lvl) begin
                start = 1'b1;
                kind  = K_IRQ;
            end
        end else if (boundary && brk) begin
            start = 1'b1;
            kind  = K_BRK;
        end
    end
endmodule

// File: rtl/ies_stack_ptr.sv
// Stack pointer register. It loads SP_INIT in reset and steps down by one
// on every stack write. It assumes no other agent changes it.
module ies_stack_ptr #(
    parameter logic [7:0] SP_INIT = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec,
    output logic [7:0] sp
);
    // Reset load and post-write decrement
    always_ff @(posedge clk) begin
        if (!rst_n) sp <= SP_INIT;
        else if (dec) sp <= sp - 8'd1;
    end

    // R2
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> (sp == $past(sp) - 8'd1));
endmodule

// File: rtl/ies_bus_mux.sv
// Drives the memory port from the sequencer state. It assumes one-cycle
// read latency, so the captures happen in the sequencer, not here.
module ies_bus_mux
    import ies_pkg::*;
(
    input  seq_state_t         state,
    input  logic [7:0]         sp,
    input  logic [ADDR_W-1:0]  pc_save,
    input  logic [DATA_W-1:0]  psw,
    input  logic [ADDR_W-1:0]  vec_base,
    output logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  wdata,
    output logic               we
);
    // Address, data and write strobe per state
    always_comb begin
        addr  = {STACK_PAGE, sp};
        wdata = '0;
        we    = 1'b0;
        case (state)
            S_PSH_H: begin wdata = pc_save[15:8]; we = 1'b1; end
            S_PSH_L: begin wdata = pc_save[7:0];  we = 1'b1; end
            S_PSH_P: begin wdata = psw;           we = 1'b1; end
            S_VLO:   addr = vec_base;
            S_VHI:   addr = vec_base + 16'd1;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt and reset entry sequencer. It pushes PC and status onto the
// page-1 stack, fetches the vector and presents the new PC, SP and status.
// Assumes: synchronous memory with one-cycle read latency; boundary, cli_req
// and brk_req are one-cycle strobes from the core; cli_req never comes
// together with boundary.
module irq_entry_seq
    import ies_pkg::*;
#(
    parameter logic [7:0] SP_INIT     = 8'hFF,
    parameter logic [7:0] STATUS_INIT = 8'h22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic              brk_req,
    input  logic              cli_req,
    input  logic              nmi_req,
    input  logic              irq_req,
    input  logic              restore_we,
    input  logic [7:0]        restore_val,
    input  logic [15:0]       pc_in,
    output logic [15:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata,
    output logic [15:0]       pc_out,
    output logic [7:0]        sp_out,
    output logic [7:0]        status_out,
    output logic              done,
    output logic              busy,
    output logic              gpr_clear,
    output logic [COST_W-1:0] entry_cost
);
    seq_state_t  state_q;
    entry_kind_t kind_q, sel_kind;
    logic [15:0] pc_save_q, vec_base;
    logic [7:0]  vec_lo_q, status_q, psw, sp;
    logic        nmi_pend_q, start, clr_i, idle;

    assign idle = (state_q == S_IDLE);

    ies_arbiter u_arb (
        .boundary (boundary & idle),
        .brk      (brk_req),
        .cli      (cli_req & idle),
        .nmi_pend (nmi_pend_q),
        .irq_lvl  (irq_req),
        .i_flag   (status_q[FB_I]),
        .start    (start),
        .kind     (sel_kind),
        .clr_i    (clr_i)
    );

    ies_stack_ptr #(.SP_INIT(SP_INIT)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (mem_we),
        .sp    (sp)
    );

    // Vector base and pushed status byte, per entry kind
    always_comb begin
        case (kind_q)
            K_NMI:   vec_base = VEC_NMI;
            K_RST:   vec_base = VEC_RST;
            default: vec_base = VEC_IRQ;
        endcase
        psw        = status_q;
        psw[FB_B]  = (kind_q == K_BRK);
        psw[FB_R]  = 1'b1;
    end

    ies_bus_mux u_mux (
        .state    (state_q),
        .sp       (sp),
        .pc_save  (pc_save_q),
        .psw      (psw),
        .vec_base (vec_base),
        .addr     (mem_addr),
        .wdata    (mem_wdata),
        .we       (mem_we)
    );

    // Sequencer state, captured return address and fetched vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_VLO;
            kind_q     <= K_RST;
            pc_save_q  <= '0;
            vec_lo_q   <= '0;
            pc_out     <= '0;
            done       <= 1'b0;
            entry_cost <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                S_IDLE: if (start) begin
                    state_q   <= S_PSH_H;
                    kind_q    <= sel_kind;
                    pc_save_q <= pc_in + ((sel_kind == K_BRK) ? 16'd1 : 16'd0);
                end
                S_PSH_H: state_q <= S_PSH_L;
                S_PSH_L: state_q <= S_PSH_P;
                S_PSH_P: state_q <= S_VLO;
                S_VLO:   state_q <= S_VHI;
                S_VHI: begin
                    vec_lo_q <= mem_rdata;
                    state_q  <= S_VWAIT;
                end
                S_VWAIT: begin
                    pc_out     <= {mem_rdata, vec_lo_q};
                    done       <= 1'b1;
                    entry_cost <= (kind_q == K_RST) ? COST_W'(0) : COST_W'(ENTRY_CLOCKS);
                    state_q    <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Non-maskable request latch, held until an entry takes it
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_pend_q <= 1'b0;
        else nmi_pend_q <= nmi_req | (nmi_pend_q & ~(start & (sel_kind == K_NMI)));
    end

    // Status byte: entry side effects, mask clear and restore
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= STATUS_INIT;
        end else if (state_q == S_PSH_P) begin
            status_q[FB_D] <= 1'b0;
            if (kind_q != K_NMI) status_q[FB_I] <= 1'b1;
        end else if (idle) begin
            if (clr_i) status_q[FB_I] <= 1'b0;
            else if (!start && restore_we) status_q <= restore_val | (8'd1 << FB_R);
        end
    end

    assign sp_out     = sp;
    assign status_out = status_q;
    assign busy       = !idle;
    assign gpr_clear  = busy && (kind_q == K_RST);

    // R2
    stack_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[15:8] == STACK_PAGE));
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && boundary && nmi_pend_q) |=> (state_q == S_PSH_H && kind_q == K_NMI));
    // R5
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && boundary && !nmi_pend_q && irq_req && status_q[FB_I] && !brk_req && !cli_req)
        |=> (state_q == S_IDLE));
    // R7
    d_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PSH_P) |=> !status_q[FB_D]);
    // R8
    cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (entry_cost == ((kind_q == K_RST) ? COST_W'(0) : COST_W'(ENTRY_CLOCKS))));
    // R9
    cli_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cli_req && !boundary && status_q[FB_I] && irq_req)
        |=> (state_q == S_PSH_H && kind_q == K_IRQ));
    // R10
    reserved_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[FB_R]);
endmodule

// File: tb/irq_entry_seq_bench.sv
`timescale 1ns/1ps
module irq_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 0, brk_req = 0, cli_req = 0, nmi_req = 0, irq_req = 0;
    logic        restore_we = 0;
    logic [7:0]  restore_val = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, mem_rdata, sp_out, status_out;
    logic        mem_we, done, busy, gpr_clear;
    logic [2:0]  entry_cost;

    int total = 0;
    int bad = 0;
    logic [7:0] stk [256];

    always #2 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .brk_req(brk_req),
        .cli_req(cli_req), .nmi_req(nmi_req), .irq_req(irq_req),
        .restore_we(restore_we), .restore_val(restore_val), .pc_in(pc_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .pc_out(pc_out), .sp_out(sp_out),
        .status_out(status_out), .done(done), .busy(busy),
        .gpr_clear(gpr_clear), .entry_cost(entry_cost)
    );

    function automatic logic [7:0] rom(input logic [15:0] a);
        case (a)
            16'hFFFA: rom = 8'h34;
            16'hFFFB: rom = 8'h12;
            16'hFFFC: rom = 8'h00;
            16'hFFFD: rom = 8'hC0;
            16'hFFFE: rom = 8'h78;
            16'hFFFF: rom = 8'h56;
            default:  rom = 8'hEE;
        endcase
    endfunction

    // Memory model: registered read, stack page writes recorded
    always @(posedge clk) begin
        mem_rdata <= rom(mem_addr);
        if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Clock until done; n counts edges from the accepting edge
    task automatic run_to_done(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
            boundary = 0; brk_req = 0; cli_req = 0; nmi_req = 0; restore_we = 0;
        end while (!done && n < 20);
    endtask

    task automatic restore(input logic [7:0] v);
        restore_val = v; restore_we = 1;
        @(posedge clk); @(negedge clk); restore_we = 0;
    endtask

    task automatic t_reset;
        int n;
        repeat (3) @(negedge clk);
        check("R1 sp in reset", sp_out, 16'h00FF);
        check("R1 status in reset", status_out, 16'h0022);
        check("R1 gpr_clear in reset", gpr_clear, 1);
        rst_n = 1;
        run_to_done(n);
        check("R1 reset cycles", n, 3);
        check("R1 reset pc", pc_out, 16'hC000);
        check("R1 reset cost", entry_cost, 0);
        @(negedge clk);
        check("R1 gpr_clear released", gpr_clear, 0);
        check("R1 sp after reset", sp_out, 16'h00FF);
    endtask

    task automatic t_irq;
        int n;
        pc_in = 16'h8000; irq_req = 1; boundary = 1;
        run_to_done(n);
        check("R8 irq cycles", n, 7);
        check("R8 irq cost", entry_cost, 7);
        check("R2 push pch", stk[8'hFF], 16'h0080);
        check("R2 push pcl", stk[8'hFE], 16'h0000);
        check("R6 irq pushed status", stk[8'hFD], 16'h0022);
        check("R2 sp after irq", sp_out, 16'h00FC);
        check("R7 irq status", status_out, 16'h0026);
        check("R3 irq vector", pc_out, 16'h5678);
        @(negedge clk);
        check("R3 done one cycle", done, 0);
    endtask

    task automatic t_masked;
        int seen = 0;
        boundary = 1;
        repeat (8) begin
            @(posedge clk); @(negedge clk); boundary = 0;
            if (done || mem_we) seen++;
        end
        check("R5 masked no entry", seen, 0);
        check("R5 masked sp", sp_out, 16'h00FC);
        check("R5 masked pc", pc_out, 16'h5678);
    endtask

    task automatic t_cli;
        int n;
        pc_in = 16'h8100; cli_req = 1;
        run_to_done(n);
        check("R9 cli immediate cycles", n, 7);
        check("R9 cli pushed pch", stk[8'hFC], 16'h0081);
        check("R9 cli pushed status I clear", stk[8'hFA], 16'h0022);
        check("R9 cli status after", status_out, 16'h0026);
        check("R9 cli sp", sp_out, 16'h00F9);
        irq_req = 0;
    endtask

    task automatic t_nmi_prio;
        int n;
        restore(8'h00);
        check("R10 restore forces R", status_out, 16'h0020);
        nmi_req = 1; @(posedge clk); @(negedge clk); nmi_req = 0;
        pc_in = 16'h8200; irq_req = 1; boundary = 1;
        run_to_done(n);
        check("R4 nmi first vector", pc_out, 16'h1234);
        check("R6 nmi pushed status B clear", stk[8'hF7], 16'h0020);
        check("R7 nmi keeps I", status_out, 16'h0020);
        check("R2 nmi pcl", stk[8'hF8], 16'h0000);
        boundary = 1;
        run_to_done(n);
        check("R4 irq after nmi", pc_out, 16'h5678);
        check("R6 irq pushed status", stk[8'hF4], 16'h0020);
        check("R7 irq sets I", status_out, 16'h0024);
        check("R2 sp after two", sp_out, 16'h00F3);
        irq_req = 0;
    endtask

    task automatic t_brk;
        int n;
        restore(8'h08);
        check("R10 restore D", status_out, 16'h0028);
        pc_in = 16'h9000; brk_req = 1; boundary = 1;
        run_to_done(n);
        check("R8 brk cycles", n, 7);
        check("R6 brk pch", stk[8'hF3], 16'h0090);
        check("R6 brk pcl plus one", stk[8'hF2], 16'h0001);
        check("R6 brk pushed status B set", stk[8'hF1], 16'h0038);
        check("R7 brk status D clear I set", status_out, 16'h0024);
        check("R3 brk vector", pc_out, 16'h5678);
    endtask

    task automatic t_nmi_held;
        int n;
        int seen = 0;
        restore(8'h00);
        pc_in = 16'hA000; irq_req = 1; boundary = 1;
        @(posedge clk); @(negedge clk); boundary = 0; nmi_req = 1;
        @(posedge clk); @(negedge clk); nmi_req = 0; irq_req = 0;
        run_to_done(n);
        check("R4 held irq vector", pc_out, 16'h5678);
        repeat (5) begin
            @(posedge clk); @(negedge clk);
            if (busy || done) seen++;
        end
        check("R4 nmi waits for boundary", seen, 0);
        boundary = 1;
        run_to_done(n);
        check("R4 held nmi taken", pc_out, 16'h1234);
        check("R8 held nmi cycles", n, 7);
        check("R2 sp after held", sp_out, 16'h00EA);
    endtask

    initial begin
        t_reset();
        t_irq();
        t_masked();
        t_cli();
        t_nmi_prio();
        t_brk();
        t_nmi_held();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule